// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 28-bit physical address for 4 KiB pages. It reads two page table entries in turn through a read port with a request/response handshake. The virtual address is cut into three fields. The top 10 bits index the first-level table. The next 10 bits index the second-level table. The low 12 bits are the byte offset inside the page. The first-level table is found from a root frame number that is supplied with each request.

A client presents an address and waits for a one-cycle completion strobe. The walker fetches the first-level entry, which names the frame that holds the second-level table. It then fetches the second-level entry, which names the physical frame. An entry with its present flag clear ends the walk at once with a one-cycle fault strobe, and no address is produced. Memory may stall the read request and may return the data after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `req_ready` is 1 and `mem_rd_valid`, `done` and `fault` are 0.
- R2: A request is taken only when `req_ready` is 1, and `req_ready` is 1 only when no walk is in progress. A `req_valid` raised while a walk runs is ignored, and the running walk ends with the result for its own address.
- R3: The first read goes to address `{root_frame, vaddr[31:22], 2'b00}`. This is the table frame times 4096 plus the index times 4, using the `root_frame` and `req_vaddr` values captured when the request was taken.
- R4: Every entry has its present flag in bit 0. If the first-level entry has bit 0 clear, the walk ends with `fault` and issues no second read, whatever its other bits hold.
- R5: If the first-level entry is present, its bits [31:16] give the frame of the second-level table. The second read goes to `{entry1[31:16], vaddr[21:12], 2'b00}`.
- R6: If the second-level entry has bit 0 clear, the walk ends with `fault` and `done` stays 0.
- R7: If the second-level entry is present, `done` rises and `paddr` equals `{entry2[31:16], vaddr[11:0]}`. Entry bits [15:1] have no effect on the result.
- R8: `done` and `fault` are each high for exactly one cycle, never together. `req_ready` returns to 1 in the next cycle.
- R9: Once `mem_rd_valid` is raised, it and `mem_rd_addr` stay unchanged until a cycle in which `mem_rd_ready` is 1. The walker accepts response data whenever `mem_rsp_valid` arrives, however many cycles later that is.
- R10: A change of `root_frame` after a request has been taken has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle; a request is accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| root_frame | input | 16 | Frame number of the first-level table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 28 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle strobe: translation succeeded |
| fault | output | 1 | One-cycle strobe: a not-present entry ended the walk |
| paddr | output | 28 | Physical address, valid while `done` is 1 |

## Verification
The bench goes after walks that fault at each level. A walker that ignored the present flag would issue a read at a junk second-level address or raise `done`. A walker that kept going after a first-level fault would make a read the bench never expected. Stalls and response latencies are varied, so a walker that dropped its request during a stall, or that moved its address, is caught at the memory port. The bench also holds `req_valid` high during a walk and changes `root_frame` mid-walk. A walker that accepted a request while busy, or that read the live root instead of the captured one, would read the wrong entries and return the wrong address. Entries carry junk in bits [15:1], which exposes a field decode that uses the wrong bits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 28;
    localparam int OFF_W    = 12;
    localparam int ENT_W    = 32;
    localparam int LO_IDX_W = 10;
    localparam int HI_IDX_W = VA_W - OFF_W - LO_IDX_W;
    localparam int FRAME_W  = PA_W - OFF_W;
    localparam int ENT_SHIFT = $clog2(ENT_W / 8);
    localparam int IDX_W    = OFF_W - ENT_SHIFT;
    localparam int LEVELS   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WT1,
        ST_RD2,
        ST_WT2,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        logic [HI_IDX_W-1:0] hi;
        logic [LO_IDX_W-1:0] lo;
        logic [OFF_W-1:0]    off;
    } va_t;

    typedef struct packed {
        logic [FRAME_W-1:0]         frame;
        logic [ENT_W-FRAME_W-2:0]   spare;
        logic                       present;
    } pte_t;

    function automatic logic [PA_W-1:0] slot_addr(
        input logic [FRAME_W-1:0] base,
        input logic [IDX_W-1:0]   idx
    );
        return {base, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SHIFT);
    endfunction

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     mem_rd_ready,
    input  logic     mem_rsp_valid,
    input  logic     pte_present,
    output walk_st_e state,
    output logic     req_ready,
    output logic     rd_valid,
    output logic     sel_l2,
    output logic     cap_req,
    output logic     cap_l1,
    output logic     cap_l2,
    output logic     done,
    output logic     fault
);

    walk_st_e state_nx;

    always_comb begin
        state_nx = state;
        cap_req  = 1'b0;
        cap_l1   = 1'b0;
        cap_l2   = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                state_nx = ST_RD1;
                cap_req  = 1'b1;
            end
            ST_RD1: if (mem_rd_ready) state_nx = ST_WT1;
            ST_WT1: if (mem_rsp_valid) begin
                if (pte_present) begin
                    state_nx = ST_RD2;
                    cap_l1   = 1'b1;
                end else begin
                    state_nx = ST_FAULT;
                end
            end
            ST_RD2: if (mem_rd_ready) state_nx = ST_WT2;
            ST_WT2: if (mem_rsp_valid) begin
                if (pte_present) begin
                    state_nx = ST_DONE;
                    cap_l2   = 1'b1;
                end else begin
                    state_nx = ST_FAULT;
                end
            end
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign req_ready = (state == ST_IDLE);
    assign rd_valid  = (state == ST_RD1) || (state == ST_RD2);
    assign sel_l2    = (state == ST_RD2);
    assign done      = (state == ST_DONE);
    assign fault     = (state == ST_FAULT);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done held");                     // R8
    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault) else $error("fault held");                  // R8
    AST_END_READY: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |=> req_ready) else $error("no return to idle"); // R8
    AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !mem_rd_ready) |=> rd_valid) else $error("read dropped"); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!rd_valid && !done && !fault)) else $error("ready while busy"); // R2

endmodule

// File: rtl/ptw_dp.sv
module ptw_dp
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_req,
    input  logic               cap_l1,
    input  logic               cap_l2,
    input  logic               sel_l2,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               pte_present,
    output logic [PA_W-1:0]    mem_rd_addr,
    output logic [PA_W-1:0]    paddr
);

    va_t                va_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] tbl_q;
    logic [FRAME_W-1:0] frame_q;
    pte_t               pte;
    logic               unused_spare;

    assign pte          = pte_t'(mem_rsp_data);
    assign pte_present  = pte.present;
    assign unused_spare = ^pte.spare;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q    <= '0;
            root_q  <= '0;
            tbl_q   <= '0;
            frame_q <= '0;
        end else begin
            if (cap_req) begin
                va_q   <= va_t'(req_vaddr);
                root_q <= root_frame;
            end
            if (cap_l1) tbl_q   <= pte.frame;
            if (cap_l2) frame_q <= pte.frame;
        end
    end

    logic [FRAME_W-1:0] lvl_base [LEVELS];
    logic [IDX_W-1:0]   lvl_idx  [LEVELS];
    logic [PA_W-1:0]    lvl_addr [LEVELS];

    assign lvl_base[0] = root_q;
    assign lvl_base[1] = tbl_q;
    assign lvl_idx[0]  = IDX_W'(va_q.hi);
    assign lvl_idx[1]  = IDX_W'(va_q.lo);

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign lvl_addr[g] = slot_addr(lvl_base[g], lvl_idx[g]);
    end

    assign mem_rd_addr = sel_l2 ? lvl_addr[1] : lvl_addr[0];
    assign paddr       = {frame_q, va_q.off};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               done,
    output logic               fault,
    output logic [PA_W-1:0]    paddr
);

    walk_st_e state;
    logic     sel_l2, cap_req, cap_l1, cap_l2, pte_present;

    ptw_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .pte_present  (pte_present),
        .state        (state),
        .req_ready    (req_ready),
        .rd_valid     (mem_rd_valid),
        .sel_l2       (sel_l2),
        .cap_req      (cap_req),
        .cap_l1       (cap_l1),
        .cap_l2       (cap_l2),
        .done         (done),
        .fault        (fault)
    );

    ptw_dp u_dp (
        .clk         (clk),
        .rst         (rst),
        .cap_req     (cap_req),
        .cap_l1      (cap_l1),
        .cap_l2      (cap_l2),
        .sel_l2      (sel_l2),
        .req_vaddr   (req_vaddr),
        .root_frame  (root_frame),
        .mem_rsp_data(mem_rsp_data),
        .pte_present (pte_present),
        .mem_rd_addr (mem_rd_addr),
        .paddr       (paddr)
    );

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> $stable(mem_rd_addr)) else $error("address moved"); // R9
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fault)) else $error("done with fault");             // R8
    AST_L2_AFTER_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && !pte_present && !req_ready && !mem_rd_valid) |=> (fault && !mem_rd_valid)) else $error("walk went on"); // R4

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [31:0] req_vaddr;
    logic [15:0] root_frame;
    logic        mem_rd_valid, mem_rd_ready;
    logic [27:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done, fault;
    logic [27:0] paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_frame(root_frame),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .paddr(paddr)
    );

    int checks = 0;
    int fails  = 0;

    bit [31:0]   mem_img [bit [27:0]];
    logic [27:0] exp_rd_q [$];
    string       exp_tag_q [$];
    bit          exp_fault;
    logic [27:0] exp_pa;
    string       exp_end_tag;
    bit          busy = 1'b1;
    bit          mon_on = 1'b0;
    int          end_cnt = 0;
    int          stall_cfg = 0, lat_cfg = 0, stall_left = 0;
    bit          stalling = 1'b0;
    logic [27:0] stall_addr;
    bit          rsp_pending = 1'b0;
    int          rsp_wait = 0;
    logic [31:0] rsp_word;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdm(input logic [27:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    // behavioural model: expected read addresses and outcome
    task automatic plan_walk(input logic [31:0] va, input logic [15:0] root);
        logic [27:0] a1, a2;
        logic [31:0] e1, e2;
        a1 = {root, va[31:22], 2'b00};
        exp_rd_q.push_back(a1); exp_tag_q.push_back("R3");
        e1 = rdm(a1);
        if (!e1[0]) begin
            exp_fault = 1'b1; exp_end_tag = "R4"; exp_pa = '0;
        end else begin
            a2 = {e1[31:16], va[21:12], 2'b00};
            exp_rd_q.push_back(a2); exp_tag_q.push_back("R5");
            e2 = rdm(a2);
            if (!e2[0]) begin
                exp_fault = 1'b1; exp_end_tag = "R6"; exp_pa = '0;
            end else begin
                exp_fault = 1'b0; exp_end_tag = "R7";
                exp_pa = {e2[31:16], va[11:0]};
            end
        end
    endtask

    // memory responder
    initial begin
        mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rsp_pending) begin
                if (rsp_wait == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = rsp_word; rsp_pending = 1'b0;
                end else rsp_wait--;
            end
            if (mem_rd_ready) begin
                mem_rd_ready = 1'b0;
            end else if (mem_rd_valid === 1'b1 && !rst) begin
                if (!stalling) begin
                    stalling = 1'b1; stall_addr = mem_rd_addr;
                end else begin
                    chk(mem_rd_addr === stall_addr, "R9", "address moved in stall",
                        32'(mem_rd_addr), 32'(stall_addr));
                end
                if (stall_left > 0) stall_left--;
                else begin
                    mem_rd_ready = 1'b1; stalling = 1'b0; stall_left = stall_cfg;
                    if (exp_rd_q.size() == 0) begin
                        chk(1'b0, "R4", "unexpected read", 32'(mem_rd_addr), 32'h0);
                    end else begin
                        chk(mem_rd_addr === exp_rd_q[0], exp_tag_q[0], "read address",
                            32'(mem_rd_addr), 32'(exp_rd_q[0]));
                        void'(exp_rd_q.pop_front()); void'(exp_tag_q.pop_front());
                    end
                    rsp_word = rdm(mem_rd_addr); rsp_pending = 1'b1; rsp_wait = lat_cfg;
                end
            end else if (stalling && !rst) begin
                chk(1'b0, "R9", "request dropped in stall", 32'(mem_rd_valid), 32'h1);
                stalling = 1'b0;
            end
        end
    end

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                chk(req_ready === !busy, "R2/R8", "req_ready vs model", 32'(req_ready), 32'(!busy));
                if (done === 1'b1 || fault === 1'b1) begin
                    chk(busy, "R2", "result with no walk", 32'(done), 32'h0);
                    chk(!(done && fault), "R8", "done and fault together", 32'(fault), 32'h0);
                    chk(fault === exp_fault, exp_end_tag, "fault outcome", 32'(fault), 32'(exp_fault));
                    if (!exp_fault)
                        chk(paddr === exp_pa, "R7", "physical address", 32'(paddr), 32'(exp_pa));
                    busy = 1'b0;
                    end_cnt++;
                end
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [15:0] root, input int st,
                        input int lt, input bit poke, input bit swap_root);
        int start;
        stall_cfg = st; lat_cfg = lt; stall_left = st;
        plan_walk(va, root);
        start = end_cnt;
        @(negedge clk);
        req_vaddr = va; root_frame = root; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0; busy = 1'b1;
        if (swap_root) root_frame = ~root;                         // R10
        if (poke) begin req_vaddr = va ^ 32'h00C0_0000; req_valid = 1'b1; end  // R2
        for (int i = 0; i < 3000 && end_cnt == start; i++) begin
            @(posedge clk); #2;
        end
        req_valid = 1'b0;
        chk(end_cnt != start, "R7", "walk finished", 32'(end_cnt - start), 32'h1);
        chk(exp_rd_q.size() == 0, "R4", "reads left unissued",
            32'(exp_rd_q.size()), 32'h0);
        exp_rd_q.delete(); exp_tag_q.delete();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; root_frame = '0;
        // tables: root 0x0010 -> L1; L1 frames 0x0020 and 0x0030; second root 0x0050
        mem_img[{16'h0010, 10'h001, 2'b00}] = 32'h0020_7FF1;
        mem_img[{16'h0010, 10'h3FF, 2'b00}] = 32'h0030_0001;
        mem_img[{16'h0010, 10'h002, 2'b00}] = 32'h0040_0000;
        mem_img[{16'h0020, 10'h002, 2'b00}] = 32'h91D8_0001;
        mem_img[{16'h0020, 10'h003, 2'b00}] = 32'h0001_ABC3;
        mem_img[{16'h0020, 10'h005, 2'b00}] = 32'h7777_0000;
        mem_img[{16'h0030, 10'h3FF, 2'b00}] = 32'hABCD_0001;
        mem_img[{16'h0050, 10'h001, 2'b00}] = 32'h0030_0001;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready in reset", 32'(req_ready), 32'h1);
        chk(mem_rd_valid === 1'b0, "R1", "read in reset", 32'(mem_rd_valid), 32'h0);
        chk(done === 1'b0 && fault === 1'b0, "R1", "strobe in reset", 32'({done, fault}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
        busy = 1'b0; mon_on = 1'b1;
        @(posedge clk); #2;

        walk(32'h0040_2204, 16'h0010, 0, 0, 0, 0);  // R7 plain walk
        walk(32'h0040_3000, 16'h0010, 2, 3, 0, 0);  // R7 zero offset, junk bits
        walk(32'hFFFF_FFFC, 16'h0010, 1, 5, 0, 0);  // R5 top indices
        walk(32'h0000_0860, 16'h0010, 0, 1, 0, 0);  // R4 absent L1 entry
        walk(32'h0080_2ABC, 16'h0010, 3, 0, 0, 0);  // R4 clear flag, nonzero frame
        walk(32'h0040_5123, 16'h0010, 0, 2, 0, 0);  // R6 absent L2 entry
        walk(32'h0040_2204, 16'h0010, 1, 2, 1, 0);  // R2 request while busy
        walk(32'hFFFF_FFFC, 16'h0010, 2, 1, 0, 1);  // R10 root change mid walk
        walk(32'h007F_F123, 16'h0050, 0, 0, 0, 0);  // R3 other root table
        walk(32'h0040_2FFF, 16'h0010, 4, 7, 0, 0);  // R9 long stall and latency
        walk(32'h0040_5000, 16'h0010, 4, 0, 1, 1);  // R6 fault with poke and root swap
        walk(32'h0040_2001, 16'h0010, 0, 0, 0, 0);  // R8 back to back
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule